// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

A bank of physical event counters behind a 64-bit register bus. Each physical counter runs either as one 32-bit counter or as two independent 16-bit halves. That gives eight logical counters, each driven by its own one-bit event input. Software never writes a live counter directly. A counter write fills a holding latch. Every pending latch is copied into its counter when the control register is written with the enable bit set, whether or not the monitor was already running.

When a logical counter wraps, its status bit is set. An interrupt output is raised while any status bit is set whose mask bit is also set. Reading the status register returns the pending bits and clears them in the same access. Writing the status register loads the interrupt mask instead. The control register and the mask are write-only, so software keeps its own copies of both.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter reads zero, the status register reads zero, the interrupt output is low and the monitor is disabled with all counters in 32-bit mode.
- R2: The word address is `bus_addr_i`. Addresses 0..3 select counters 0..3, address 4 selects control and address 5 selects status; any other address reads zero. Register data travels in bits 63:32 of the bus word, and bits 31:0 read as zero. Read data appears on `bus_rdata_o` one cycle after the read strobe. A control read returns zero.
- R3: A counter write only loads that counter's holding latch. Reads return the live counter, so a pending value is invisible until a control write with bit 0 (enable) set copies it in.
- R4: Such a commit also happens when the monitor is already enabled. It affects only counters with a pending latch; other counters keep their value.
- R5: With control bit 0 clear, no counter changes on events.
- R6: In 32-bit mode, counter n (n = 0..3) increments by one on every enabled cycle in which `event_i[n]` is high, and `event_i[n+4]` has no effect on it.
- R7: With control bit 4+n set, counter n is split. `event_i[n]` increments bits 31:16 and `event_i[n+4]` increments bits 15:0, and each half wraps within itself without carrying into the other.
- R8: A logical counter wrapping from all ones to zero sets its status bit. In 32-bit mode that is bit n; in split mode it is bit n for the upper half and bit n+4 for the lower half.
- R9: A status read returns the status bits (register bits 7:0) and clears them. A wrap in the same cycle as the read stays set.
- R10: A status write loads the interrupt mask from register bits 7:0. `irq_o` is high exactly while some status bit and its mask bit are both set, so writing zero silences it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 64 | Write data, register in bits 63:32 |
| bus_rdata_o | output | 64 | Read data, one cycle after the read strobe |
| event_i | input | 8 | Increment request per logical counter |
| irq_o | output | 1 | Masked status interrupt |

## Verification
Single counters are driven in 32-bit mode, including by the lower-half event input that must not touch them. Split counters are driven through each half separately, which shows whether a half wrap carries into its neighbour and whether the right status bit is picked. Counter writes are followed by reads before and after a commit, and once while the monitor is already running. This separates the latch from the live counter and shows that a commit touches only pending counters. Status bits are checked against one mask that covers them and another that does not, which shows both clear-on-read and the masking of the interrupt.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned BUS_W      = 64;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned SPLIT_LSB  = 4;
endpackage

// File: rtl/pmc_phys_ctr.sv
module pmc_phys_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             split_i,
  input  logic             ev_hi_i,
  input  logic             ev_lo_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             commit_i,
  output logic [CNT_W-1:0] value_o,
  output logic             wrap_hi_o,
  output logic             wrap_lo_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cnt_q, cnt_d, latch_q;
  logic              pend_q, load;
  logic [HALF_W-1:0] hi, lo;

  assign load = commit_i & pend_q;
  assign hi   = cnt_q[CNT_W-1:HALF_W];
  assign lo   = cnt_q[HALF_W-1:0];

  always_comb begin
    cnt_d     = cnt_q;
    wrap_hi_o = 1'b0;
    wrap_lo_o = 1'b0;
    if (load) begin
      cnt_d = latch_q;
    end else if (en_i) begin
      if (split_i) begin
        if (ev_hi_i) begin
          cnt_d[CNT_W-1:HALF_W] = hi + 1'b1;
          wrap_hi_o = &hi;
        end
        if (ev_lo_i) begin
          cnt_d[HALF_W-1:0] = lo + 1'b1;
          wrap_lo_o = &lo;
        end
      end else if (ev_hi_i) begin
        cnt_d     = cnt_q + 1'b1;
        wrap_hi_o = &cnt_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_i) begin
        latch_q <= wdata_i;
        pend_q  <= 1'b1;
      end else if (load) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign value_o = cnt_q;

  p_hold_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load) |=> $stable(cnt_q));
  p_half_isolation_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && !ev_hi_i && !load) |=> cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W]));
  p_commit_loads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> cnt_q == $past(latch_q));
endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
  parameter int unsigned NUM_LOG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LOG-1:0] wrap_i,
  input  logic               clr_i,
  input  logic               mask_wr_i,
  input  logic [NUM_LOG-1:0] mask_i,
  output logic [NUM_LOG-1:0] status_o,
  output logic               irq_o
);
  logic [NUM_LOG-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (clr_i ? '0 : status_q) | wrap_i;
      if (mask_wr_i) mask_q <= mask_i;
    end
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_q);

  p_wrap_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i != '0) |=> ((status_o & $past(wrap_i)) == $past(wrap_i)));
  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> status_o == $past(wrap_i));
  p_mask_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_i == '0) |=> !irq_o);
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = $clog2(NUM_PHYS + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_en_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [BUS_W-1:0]      bus_wdata_i,
  output logic [BUS_W-1:0]      bus_rdata_o,
  input  logic [2*NUM_PHYS-1:0] event_i,
  output logic                  irq_o
);
  localparam int unsigned NUM_LOG   = 2 * NUM_PHYS;
  localparam int unsigned CTRL_ADDR = NUM_PHYS;
  localparam int unsigned STAT_ADDR = NUM_PHYS + 1;

  logic [REG_W-1:0]   wreg, ctrl_q, rd_val;
  logic [BUS_W-1:0]   rdata_q;
  logic               wr, rd, ctrl_wr, commit, stat_rd, stat_wr;
  logic [NUM_LOG-1:0] wrap_vec, status;
  logic [CNT_W-1:0]   cnt_val [NUM_PHYS];
  logic               unused_bits;

  assign wreg    = bus_wdata_i[BUS_W-1:REG_W];
  assign wr      = bus_en_i & bus_we_i;
  assign rd      = bus_en_i & ~bus_we_i;
  assign ctrl_wr = wr & (32'(bus_addr_i) == CTRL_ADDR);
  assign commit  = ctrl_wr & wreg[EN_BIT];
  assign stat_rd = rd & (32'(bus_addr_i) == STAT_ADDR);
  assign stat_wr = wr & (32'(bus_addr_i) == STAT_ADDR);
  assign unused_bits = ^{bus_wdata_i[REG_W-1:0], wreg[REG_W-1:NUM_LOG]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wreg;
  end

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_ctr
    pmc_phys_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (ctrl_q[EN_BIT]),
      .split_i   (ctrl_q[SPLIT_LSB+n]),
      .ev_hi_i   (event_i[n]),
      .ev_lo_i   (event_i[n+NUM_PHYS]),
      .wr_i      (wr & (32'(bus_addr_i) == n)),
      .wdata_i   (wreg[CNT_W-1:0]),
      .commit_i  (commit),
      .value_o   (cnt_val[n]),
      .wrap_hi_o (wrap_vec[n]),
      .wrap_lo_o (wrap_vec[n+NUM_PHYS])
    );
  end

  pmc_status #(.NUM_LOG(NUM_LOG)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap_vec),
    .clr_i     (stat_rd),
    .mask_wr_i (stat_wr),
    .mask_i    (wreg[NUM_LOG-1:0]),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (32'(bus_addr_i) < NUM_PHYS) rd_val = REG_W'(cnt_val[bus_addr_i]);
    else if (32'(bus_addr_i) == STAT_ADDR) rd_val = REG_W'(status);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= {rd_val, {REG_W{1'b0}}};
  end

  assign bus_rdata_o = rdata_q;

  p_ctrl_write_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && 32'(bus_addr_i) == CTRL_ADDR) |=> bus_rdata_o == '0);
  p_status_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> bus_rdata_o[BUS_W-1:REG_W] == REG_W'($past(status)));
endmodule

// File: tb/pmc_bank_tb_top.sv
module pmc_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  ev = '0;
  logic        irq;
  logic        rd_q = 1'b0;
  int          n_chk = 0, n_fail = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  pmc_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .event_i(ev), .irq_o(irq)
  );

  always @(posedge clk) rd_q <= bus_en & ~bus_we;

  // monitor: read data valid at the negedge after the read edge
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = {d, 32'hDEAD_BEEF};
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back({e, 32'h0});
    tag_q.push_back(t);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int k, input int cycles);
    @(negedge clk);
    ev[k] = 1'b1;
    repeat (cycles) @(negedge clk);
    ev[k] = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    for (int i = 0; i < 4; i++) rd(3'(i), 32'h0, "R1 counter after reset");
    rd(3'd5, 32'h0, "R1 status after reset");
    pulse(0, 4);
    rd(3'd0, 32'h0, "R1 disabled after reset");
    // R3 latch then commit
    wr(3'd0, 32'h100);
    rd(3'd0, 32'h0, "R3 latch invisible");
    wr(3'd4, 32'h1);
    rd(3'd0, 32'h100, "R3 committed on enable");
    rd(3'd4, 32'h0, "R2 control write-only");
    rd(3'd6, 32'h0, "R2 unmapped reads zero");
    // R6 32-bit counting
    pulse(0, 5);
    rd(3'd0, 32'h105, "R6 increments");
    pulse(4, 3);
    rd(3'd0, 32'h105, "R6 lower event ignored in 32-bit mode");
    // R4 commit while enabled, pending only
    wr(3'd1, 32'h55);
    rd(3'd1, 32'h0, "R3 latch invisible while enabled");
    wr(3'd4, 32'h1);
    rd(3'd1, 32'h55, "R4 commit while enabled");
    rd(3'd0, 32'h105, "R4 non-pending untouched");
    // R5 disabled
    wr(3'd4, 32'h0);
    pulse(0, 3);
    rd(3'd0, 32'h105, "R5 no count when disabled");
    // R8/R9/R10 32-bit wrap
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd4, 32'h1);
    pulse(2, 3);
    rd(3'd2, 32'h1, "R8 32-bit wrap value");
    chk_irq(1'b0, "R10 unmasked status no irq");
    wr(3'd5, 32'h04);
    chk_irq(1'b1, "R10 masked status raises irq");
    rd(3'd5, 32'h04, "R9 status read returns bit 2");
    chk_irq(1'b0, "R9 read clears irq");
    rd(3'd5, 32'h0, "R9 status cleared");
    // R7 split mode on counter 3
    wr(3'd3, 32'hFFFE_0010);
    wr(3'd4, 32'h81);
    rd(3'd3, 32'hFFFE_0010, "R7 split commit");
    pulse(3, 3);
    rd(3'd3, 32'h0001_0010, "R7 upper wraps without carry");
    pulse(7, 2);
    rd(3'd3, 32'h0001_0012, "R7 lower half counts");
    wr(3'd3, 32'h0000_FFFF);
    wr(3'd4, 32'h81);
    pulse(7, 1);
    rd(3'd3, 32'h0, "R7 lower wraps without carry");
    chk_irq(1'b0, "R10 bits 3,7 not masked");
    wr(3'd5, 32'h80);
    chk_irq(1'b1, "R10 bit 7 masked");
    wr(3'd5, 32'h0);
    chk_irq(1'b0, "R10 zero mask silences");
    rd(3'd5, 32'h88, "R8 split wrap bits 3 and 7");
    rd(3'd5, 32'h0, "R9 cleared after read");
    rd(3'd0, 32'h105, "R6 counter 0 unaffected by split");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule